// File: doc/BRIEF.md
# Multiplexed Memory Bus Cycle Sequencer

This block runs single memory read and write cycles on a bus whose low lines carry the address in the first phase and data afterwards. A local client raises `start` for one clock together with a word address, a direction flag, two byte enables and write data. The sequencer then walks the bus through T1, T2, T3, any number of wait states Tw, and T4. It returns a one-clock `done` in T4, and `rd_data` is valid in that clock.

The four upper address lines and the active-low high-byte enable carry address information only in T1 and status bits after it. A three-bit encoded cycle status tells an external command decoder what kind of cycle is running. That status goes active in the clock where the request is taken. It falls back to passive in the T3 or Tw clock where READY is high, which marks the end of the cycle.

A request may be taken while the bus is idle or while it is in T4. Taking it in T4 lets cycles follow one another with no idle clock between them. `can_start` shows in which clocks a request is taken.

Top module: `bus_cycle_seq`

## Requirements
- R1: When no cycle runs, `ad_oe` and `ah_oe` are 0, `stat_out` is 111, `done` is 0 and `can_start` is 1.
- R2: In a clock where `start` is high and `can_start` is 1, `stat_out` already shows the new cycle's code: 101 for a read and 110 for a write.
- R3: In T1, `ad_oe` is 1 and `ad_out` equals {`start_addr`[DATA_W-1:1], NOT `start_be`[0]}. `ah_out` equals `start_addr`[ADDR_W-1:DATA_W] and `ah_oe` is 1. `bhe_n_out` is NOT `start_be`[1]. All of these use the request values latched when the request was taken. (`start_be`[0] enables the low byte and `start_be`[1] enables the high byte.)
- R4: In T2, T3, every Tw and T4, `ah_oe` is 1 and `ah_out` carries the fixed status 4'b1011 (most significant bit first). `bhe_n_out` carries a status bit of 1.
- R5: The cycle code stays on `stat_out` through T1 and T2. In T3 and Tw, `stat_out` is 111 in the clock where `ready` is 1 and the cycle code otherwise. In T4 with no new request, `stat_out` is 111.
- R6: `ready` low in T3 or in a Tw adds one more Tw. `ready` high in T3 or in a Tw leads to T4 on the next clock.
- R7: On a read, `ad_oe` is 0 from T2 through T4. `rd_data` in T4 equals `ad_in` as sampled in the clock where `ready` was high.
- R8: On a write, `ad_oe` is 1 and `ad_out` equals the latched write data from T2 through T4.
- R9: `done` is high for exactly the T4 clock of each cycle.
- R10: A request taken in T4 starts its T1 on the very next clock.
- R11: `start` is ignored while `can_start` is 0, which is the case from T1 through the last Tw. It neither changes the running cycle nor starts a new one.
- R12: `stat_out` only ever shows 101, 110 or 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request for one cycle |
| start_addr | input | ADDR_W-1 | Word address, bits ADDR_W-1 down to 1 |
| start_write | input | 1 | 1 = write, 0 = read |
| start_be | input | 2 | Byte enables: bit 0 low byte, bit 1 high byte |
| start_wdata | input | DATA_W | Write data |
| can_start | output | 1 | A request is taken in this clock |
| done | output | 1 | Cycle finishes (T4) |
| rd_data | output | DATA_W | Captured read data |
| ad_out | output | DATA_W | Address/data lines, driven value |
| ad_oe | output | 1 | Output enable for `ad_out` |
| ad_in | input | DATA_W | Address/data lines, sampled value |
| ah_out | output | ADDR_W-DATA_W | Upper address / status lines |
| ah_oe | output | 1 | Output enable for `ah_out` and `bhe_n_out` |
| bhe_n_out | output | 1 | Active-low high-byte enable / status bit |
| stat_out | output | 3 | Encoded cycle status |
| ready | input | 1 | Bus ready from memory |

## Verification
The status code is due in the same clock as the request, because it follows `start` without a register in between. T1 follows one clock later, T2 after two clocks, and T3 after three. T4 and `done` arrive one clock after the first clock in which `ready` is high. The driver changes inputs on the falling edge and checks the phase outputs one time unit later, stepping one falling edge per phase. The number of edges between the request and `done` therefore pins down the wait count. The scoreboard monitor samples two units after the falling edge, so it reads `rd_data` or the write data exactly in the `done` clock and compares it with the item pushed when the request was issued.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_TW   = 3'd4,
        PH_T4   = 3'd5
    } phase_e;

    localparam logic [2:0] ST_MEMRD   = 3'b101;
    localparam logic [2:0] ST_MEMWR   = 3'b110;
    localparam logic [2:0] ST_PASSIVE = 3'b111;

    function automatic logic [2:0] cycle_code(input logic wr);
        return wr ? ST_MEMWR : ST_MEMRD;
    endfunction

endpackage

// File: rtl/bcs_phase_ctrl.sv
module bcs_phase_ctrl
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:1] start_addr,
    input  logic              start_write,
    input  logic [1:0]        start_be,
    input  logic [DATA_W-1:0] start_wdata,
    input  logic              ready,
    input  logic [DATA_W-1:0] ad_in,
    output phase_e            phase,
    output logic              can_start,
    output logic [ADDR_W-1:1] cur_addr,
    output logic              cur_write,
    output logic [1:0]        cur_be,
    output logic [DATA_W-1:0] cur_wdata,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        phase_e              phase;
        logic [ADDR_W-1:1]   addr;
        logic                write;
        logic [1:0]          be;
        logic [DATA_W-1:0]   wdata;
        logic [DATA_W-1:0]   rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic take;

    always_comb begin
        ctl_d = ctl_q;
        take  = start && ((ctl_q.phase == PH_IDLE) || (ctl_q.phase == PH_T4));
        unique case (ctl_q.phase)
            PH_IDLE, PH_T4: begin
                if (take) begin
                    ctl_d.phase = PH_T1;
                    ctl_d.addr  = start_addr;
                    ctl_d.write = start_write;
                    ctl_d.be    = start_be;
                    ctl_d.wdata = start_wdata;
                end else begin
                    ctl_d.phase = PH_IDLE;
                end
            end
            PH_T1: ctl_d.phase = PH_T2;
            PH_T2: ctl_d.phase = PH_T3;
            PH_T3, PH_TW: begin
                if (ready) begin
                    ctl_d.phase = PH_T4;
                    if (!ctl_q.write) begin
                        ctl_d.rdata = ad_in;
                    end
                end else begin
                    ctl_d.phase = PH_TW;
                end
            end
            default: ctl_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign phase     = ctl_q.phase;
    assign can_start = (ctl_q.phase == PH_IDLE) || (ctl_q.phase == PH_T4);
    assign cur_addr  = ctl_q.addr;
    assign cur_write = ctl_q.write;
    assign cur_be    = ctl_q.be;
    assign cur_wdata = ctl_q.wdata;
    assign rd_data   = ctl_q.rdata;

    AST_WAIT_EXTENDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_T3 || phase == PH_TW) && !ready) |=> (phase == PH_TW)); // R6
    AST_READY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_T3 || phase == PH_TW) && ready) |=> (phase == PH_T4)); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T4) |=> (phase != PH_T4)); // R9
    AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T4 && start) |=> (phase == PH_T1)); // R10
    AST_BUSY_HOLDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T2 || phase == PH_T3 || phase == PH_TW) |=> $stable(cur_addr) && $stable(cur_write)); // R11

endmodule

// File: rtl/bcs_pin_drive.sv
module bcs_pin_drive
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  phase_e                   phase,
    input  logic                     start,
    input  logic                     start_write,
    input  logic                     ready,
    input  logic [ADDR_W-1:1]        cur_addr,
    input  logic                     cur_write,
    input  logic [1:0]               cur_be,
    input  logic [DATA_W-1:0]        cur_wdata,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] ah_out,
    output logic                     ah_oe,
    output logic                     bhe_n_out,
    output logic [2:0]               stat_out
);

    localparam int UP_W = ADDR_W - DATA_W;
    localparam logic [UP_W-1:0] UP_ONE  = {{(UP_W-1){1'b0}}, 1'b1};
    localparam logic [UP_W-1:0] UP_STAT = ~(UP_ONE << (UP_W - 2));

    logic data_phase;

    always_comb begin
        data_phase = (phase == PH_T2) || (phase == PH_T3) ||
                     (phase == PH_TW) || (phase == PH_T4);
        ad_out    = '0;
        ad_oe     = 1'b0;
        ah_out    = '0;
        ah_oe     = (phase != PH_IDLE);
        bhe_n_out = 1'b1;
        stat_out  = ST_PASSIVE;

        if (phase == PH_T1) begin
            ad_out    = {cur_addr[DATA_W-1:1], ~cur_be[0]};
            ad_oe     = 1'b1;
            ah_out    = cur_addr[ADDR_W-1:DATA_W];
            bhe_n_out = ~cur_be[1];
        end else if (data_phase) begin
            ah_out = UP_STAT;
            if (cur_write) begin
                ad_out = cur_wdata;
                ad_oe  = 1'b1;
            end
        end

        unique case (phase)
            PH_IDLE, PH_T4: stat_out = start ? cycle_code(start_write) : ST_PASSIVE;
            PH_T1, PH_T2:   stat_out = cycle_code(cur_write);
            PH_T3, PH_TW:   stat_out = ready ? ST_PASSIVE : cycle_code(cur_write);
            default:        stat_out = ST_PASSIVE;
        endcase
    end

    AST_STAT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_out == ST_MEMRD) || (stat_out == ST_MEMWR) || (stat_out == ST_PASSIVE)); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !start) |-> (!ad_oe && !ah_oe && stat_out == ST_PASSIVE)); // R1
    AST_EARLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T1 || phase == PH_T2) |-> (stat_out != ST_PASSIVE)); // R5
    AST_READ_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (data_phase && !cur_write) |-> !ad_oe); // R7
    AST_WRITE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_phase && cur_write) |-> (ad_oe && ad_out == cur_wdata)); // R8

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [ADDR_W-1:1]        start_addr,
    input  logic                     start_write,
    input  logic [1:0]               start_be,
    input  logic [DATA_W-1:0]        start_wdata,
    output logic                     can_start,
    output logic                     done,
    output logic [DATA_W-1:0]        rd_data,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [ADDR_W-DATA_W-1:0] ah_out,
    output logic                     ah_oe,
    output logic                     bhe_n_out,
    output logic [2:0]               stat_out,
    input  logic                     ready
);

    phase_e              phase;
    logic [ADDR_W-1:1]   cur_addr;
    logic                cur_write;
    logic [1:0]          cur_be;
    logic [DATA_W-1:0]   cur_wdata;

    bcs_phase_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_addr  (start_addr),
        .start_write (start_write),
        .start_be    (start_be),
        .start_wdata (start_wdata),
        .ready       (ready),
        .ad_in       (ad_in),
        .phase       (phase),
        .can_start   (can_start),
        .cur_addr    (cur_addr),
        .cur_write   (cur_write),
        .cur_be      (cur_be),
        .cur_wdata   (cur_wdata),
        .rd_data     (rd_data)
    );

    bcs_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase       (phase),
        .start       (start),
        .start_write (start_write),
        .ready       (ready),
        .cur_addr    (cur_addr),
        .cur_write   (cur_write),
        .cur_be      (cur_be),
        .cur_wdata   (cur_wdata),
        .ad_out      (ad_out),
        .ad_oe       (ad_oe),
        .ah_out      (ah_out),
        .ah_oe       (ah_oe),
        .bhe_n_out   (bhe_n_out),
        .stat_out    (stat_out)
    );

    assign done = (phase == PH_T4);

endmodule

// File: tb/bus_cycle_seq_bench.sv
module bus_cycle_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 20;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:1] start_addr = '0;
    logic          start_write = 1'b0;
    logic [1:0]    start_be = '0;
    logic [DW-1:0] start_wdata = '0;
    logic          can_start, done, ad_oe, ah_oe, bhe_n_out;
    logic [DW-1:0] rd_data, ad_out;
    logic [DW-1:0] ad_in = '0;
    logic [AW-DW-1:0] ah_out;
    logic [2:0]    stat_out;
    logic          ready = 1'b0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        bit          wr;
        logic [DW-1:0] val;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_cycle_seq #(.ADDR_W(AW), .DATA_W(DW)) u_bus_cycle_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .start_write(start_write), .start_be(start_be), .start_wdata(start_wdata),
        .can_start(can_start), .done(done), .rd_data(rd_data), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_in(ad_in), .ah_out(ah_out), .ah_oe(ah_oe),
        .bhe_n_out(bhe_n_out), .stat_out(stat_out), .ready(ready)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle_check();
        chk(ad_oe == 1'b0, "R1 ad_oe", ad_oe, 0);
        chk(ah_oe == 1'b0, "R1 ah_oe", ah_oe, 0);
        chk(stat_out == 3'b111, "R1 stat", stat_out, 3'b111);
        chk(done == 1'b0, "R1/R9 done", done, 0);
        chk(can_start == 1'b1, "R1 can_start", can_start, 1);
    endtask

    // Issues one cycle starting in the current clock; returns in its T4 clock.
    task automatic do_cyc(input bit wr, input logic [AW-1:1] a, input logic [1:0] be,
                          input logic [DW-1:0] wd, input logic [DW-1:0] rdv,
                          input int waits, input bit poke);
        logic [2:0] code;
        exp_t it;
        code = wr ? 3'b110 : 3'b101;
        start = 1'b1; start_write = wr; start_addr = a; start_be = be; start_wdata = wd;
        it.wr = wr; it.val = wr ? wd : rdv;
        sb.push_back(it);
        #1;
        chk(can_start == 1'b1, "R2 can_start", can_start, 1);
        chk(stat_out == code, "R2 stat", stat_out, code);
        // T1
        @(negedge clk);
        start = 1'b0; start_addr = ~a; start_be = ~be; start_wdata = ~wd;
        #1;
        chk(ad_oe == 1'b1, "R3 ad_oe", ad_oe, 1);
        chk(ad_out == {a[DW-1:1], ~be[0]}, "R3 ad_out", ad_out, {a[DW-1:1], ~be[0]});
        chk(ah_oe == 1'b1 && ah_out == a[AW-1:DW], "R3 ah_out", ah_out, a[AW-1:DW]);
        chk(bhe_n_out == ~be[1], "R3 bhe_n", bhe_n_out, ~be[1]);
        chk(stat_out == code, "R5 stat T1", stat_out, code);
        if (poke) begin
            start = 1'b1; start_write = ~wr;
        end
        // T2
        @(negedge clk);
        #1;
        chk(ah_out == 4'b1011 && ah_oe, "R4 ah status", ah_out, 4'b1011);
        chk(bhe_n_out == 1'b1, "R4 bhe status", bhe_n_out, 1);
        chk(stat_out == code, "R5 stat T2", stat_out, code);
        if (wr) chk(ad_oe && ad_out == wd, "R8 wdata T2", ad_out, wd);
        else    chk(ad_oe == 1'b0, "R7 float T2", ad_oe, 0);
        if (poke) chk(can_start == 1'b0, "R11 can_start", can_start, 0);
        start = 1'b0;
        // T3
        @(negedge clk);
        ready = (waits == 0);
        ad_in = ready ? rdv : ~rdv;
        #1;
        chk(stat_out == (ready ? 3'b111 : code), "R5 stat T3", stat_out, ready ? 3'b111 : code);
        chk(done == 1'b0, "R6 done T3", done, 0);
        for (int i = 0; i < waits; i++) begin
            @(negedge clk);
            ready = (i == waits - 1);
            ad_in = ready ? rdv : ~rdv;
            #1;
            chk(stat_out == (ready ? 3'b111 : code), "R5 stat Tw", stat_out, ready ? 3'b111 : code);
            chk(done == 1'b0, "R6 done Tw", done, 0);
            chk(ah_out == 4'b1011, "R4 ah Tw", ah_out, 4'b1011);
            if (!wr) chk(ad_oe == 1'b0, "R7 float Tw", ad_oe, 0);
        end
        // T4
        @(negedge clk);
        ready = 1'b0; ad_in = 16'hDEAD;
        #1;
        chk(done == 1'b1, "R6/R9 done T4", done, 1);
        chk(can_start == 1'b1, "R10 can_start T4", can_start, 1);
        chk(stat_out == 3'b111, "R5 stat T4", stat_out, 3'b111);
    endtask

    // Scoreboard monitor: compares results in the done clock.
    always @(negedge clk) begin
        #2;
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R9 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (e.wr) chk(ad_oe && ad_out == e.val, "R8 wdata T4", ad_out, e.val);
                else      chk(ad_oe == 1'b0 && rd_data == e.val, "R7 rd_data", rd_data, e.val);
            end
        end
    end

    initial begin
        repeat (3000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        idle_check(); // R1 under reset
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        idle_check(); // R1 after reset

        @(negedge clk);
        do_cyc(1'b0, 19'h2A5B3, 2'b11, 16'h0000, 16'h1234, 0, 1'b0); // read, no waits
        @(negedge clk); #1; idle_check();

        @(negedge clk);
        do_cyc(1'b1, 19'h51C07, 2'b01, 16'hBEEF, 16'h0000, 2, 1'b0); // write low byte, 2 waits
        @(negedge clk); #1; idle_check();

        @(negedge clk);
        do_cyc(1'b0, 19'h7FFFF, 2'b10, 16'h0000, 16'hA5C3, 3, 1'b1); // read high byte, start poked while busy
        @(negedge clk); #1; idle_check(); // R11: poke started nothing

        @(negedge clk);
        do_cyc(1'b1, 19'h00001, 2'b11, 16'h5A5A, 16'h0000, 1, 1'b0);
        do_cyc(1'b0, 19'h4321F, 2'b01, 16'h0000, 16'h0F0F, 0, 1'b0); // R10 back to back
        do_cyc(1'b1, 19'h6ABCD, 2'b10, 16'hC001, 16'h0000, 0, 1'b0); // R10 again
        @(negedge clk); #1; idle_check();
        chk(sb.size() == 0, "R9 all done seen", sb.size(), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule